// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of one SDRAM access burst inside an open row. A controller pulses a start strobe with the first column of the access. The block then walks through the columns of that burst, one step each cycle in which the controller asserts advance. The walk follows the programmed burst length and ordering. A last-beat flag marks the final column so that the controller can close out the access without keeping its own count.

Length and ordering come from mode fields, which are captured when the start strobe is taken. Fixed lengths of 1, 2, 4 and 8 beats wrap inside an aligned group of columns. The wrap is either sequential or interleaved. Full-page bursts run through the whole 512-column row and wrap from the top column back to column 0. A full-page burst ends only when terminate is asserted. If the single-write option is set and the access is flagged as a write, the burst is cut to one beat. A fresh start strobe may come in any cycle, and it always restarts the walk from the new column.

Top module: `sdram_burst_colgen`

## Requirements
- R1: Whenever `valid_o` is low, both `col_o` and `last_o` read 0. After reset, the block is idle, and advance or terminate alone leave it idle.
- R2: A start sampled at a clock edge makes `valid_o` high and `col_o` equal to the start column from the next cycle onward. Mode inputs are captured only at a start, so changing them during a burst has no effect.
- R3: In sequential order with length BL = 2^k, beat i outputs the start column with its low k bits replaced by (start low bits + i) mod BL. The upper bits stay as they were at the start.
- R4: In interleaved order (`ilv_mode_i` = 1) with length BL = 2^k, beat i outputs the start column with its low k bits XORed with i.
- R5: Length code `bl_code_i` values: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. The reserved codes 4, 5 and 6 behave as length 1.
- R6: `last_o` is high exactly on beat BL-1 of a fixed-length burst. If advance is taken on that beat, `valid_o` goes low in the next cycle.
- R7: While advance is low, and there is no start or terminate, the burst holds: `col_o` and `valid_o` do not change.
- R8: In full-page mode, beat i outputs (start + i) mod 512 whatever the value of `ilv_mode_i`. `last_o` never asserts, and the burst continues past 512 beats.
- R9: Terminate during a burst makes `valid_o` low in the next cycle. It takes priority over advance.
- R10: A start during an active burst restarts from the new column with beat 0. It takes priority over terminate and advance in the same cycle.
- R11: When `single_wr_i` = 1 and `is_write_i` = 1 at the start, the burst has one beat whatever the length code. When `is_write_i` = 0, the programmed length applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new burst at the start column |
| start_col_i | input | 9 | First column of the burst |
| bl_code_i | input | 3 | Burst length code (see R5) |
| ilv_mode_i | input | 1 | 1 = interleaved order, 0 = sequential |
| single_wr_i | input | 1 | Cut write bursts to one beat |
| is_write_i | input | 1 | The access being started is a write |
| advance_i | input | 1 | Step to the next beat |
| terminate_i | input | 1 | End the current burst |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A burst is in progress and `col_o` is meaningful |
| last_o | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
The properties assume that every control and mode input holds a known 0 or 1 at each rising edge after reset. They also assume that the start column and length code are stable across the edge at which the start is taken. The stimulus changes inputs only on falling edges and drives defined values from the first cycle. The reference model in the bench predicts each cycle from the requirements, so the start, advance, terminate and mode combinations stay inside what the properties expect. This covers simultaneous start with terminate, and mode changes in the middle of a burst.

// File: rtl/sdram_bcg_pkg.sv
package sdram_bcg_pkg;

   typedef enum logic [2:0] {
      BLC_ONE  = 3'd0,
      BLC_TWO  = 3'd1,
      BLC_FOUR = 3'd2,
      BLC_EIGHT= 3'd3,
      BLC_PAGE = 3'd7
   } blen_code_e;

   // log2 of the fixed burst length chosen by a code; reserved codes map to 0
   function automatic int unsigned blen_log2(input logic [2:0] code);
      case (code)
         BLC_TWO:   return 1;
         BLC_FOUR:  return 2;
         BLC_EIGHT: return 3;
         default:   return 0;
      endcase
   endfunction

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
   import sdram_bcg_pkg::*;
#(
   parameter int COL_W = 9
)(
   input  logic [2:0]       code_i,
   input  logic             single_wr_i,
   input  logic             is_write_i,
   output logic [COL_W-1:0] wrap_mask_o,
   output logic             full_o
);

   localparam int LOG_W = 2;

   logic             force_one;
   logic [LOG_W-1:0] len_log;

   assign force_one = single_wr_i & is_write_i;
   assign full_o    = (code_i == BLC_PAGE) & ~force_one;
   assign len_log   = force_one ? '0 : LOG_W'(blen_log2(code_i));

   for (genvar b = 0; b < COL_W; b++) begin : g_mask
      if (b < 4) begin : g_low
         assign wrap_mask_o[b] = full_o | (LOG_W'(b) < len_log);
      end else begin : g_high
         assign wrap_mask_o[b] = full_o;
      end
   end

endmodule

// File: rtl/bcg_beat_seq.sv
module bcg_beat_seq #(
   parameter int COL_W = 9
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             full_i,
   input  logic             ilv_i,
   input  logic             advance_i,
   input  logic             terminate_i,
   output logic             active_o,
   output logic [COL_W-1:0] beat_o,
   output logic [COL_W-1:0] base_o,
   output logic [COL_W-1:0] mask_o,
   output logic             ilv_o,
   output logic             last_o
);

   logic full_q;

   assign last_o = active_o & ~full_q & ((beat_o & mask_o) == mask_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_o <= 1'b0;
         beat_o   <= '0;
         base_o   <= '0;
         mask_o   <= '0;
         ilv_o    <= 1'b0;
         full_q   <= 1'b0;
      end else if (start_i) begin
         active_o <= 1'b1;
         beat_o   <= '0;
         base_o   <= start_col_i;
         mask_o   <= mask_i;
         ilv_o    <= ilv_i & ~full_i;
         full_q   <= full_i;
      end else if (active_o) begin
         if (terminate_i) begin
            active_o <= 1'b0;
         end else if (advance_i) begin
            if (last_o) active_o <= 1'b0;
            else        beat_o   <= beat_o + 1'b1;
         end
      end
   end

endmodule

// File: rtl/bcg_col_map.sv
module bcg_col_map #(
   parameter int COL_W  = 9,
   parameter bit ILV_EN = 1'b1
)(
   input  logic             active_i,
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             ilv_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] seq_col;
   logic [COL_W-1:0] low_col;

   assign seq_col = base_i + beat_i;

   if (ILV_EN) begin : g_ilv
      assign low_col = ilv_i ? (base_i ^ beat_i) : seq_col;
   end else begin : g_seq_only
      logic unused_ilv;
      assign unused_ilv = ilv_i;
      assign low_col    = seq_col;
   end

   assign col_o = active_i ? ((base_i & ~mask_i) | (low_col & mask_i)) : '0;

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
   parameter int COL_W  = 9,
   parameter bit ILV_EN = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [2:0]       bl_code_i,
   input  logic             ilv_mode_i,
   input  logic             single_wr_i,
   input  logic             is_write_i,
   input  logic             advance_i,
   input  logic             terminate_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o
);

   if (COL_W < 4) begin : g_bad_width
      $error("sdram_burst_colgen: COL_W must cover an 8-beat group");
   end

   logic [COL_W-1:0] dec_mask;
   logic             dec_full;
   logic [COL_W-1:0] beat_q, base_q, mask_q;
   logic             ilv_q;

   bcg_len_decode #(.COL_W(COL_W)) u_dec (
      .code_i      (bl_code_i),
      .single_wr_i (single_wr_i),
      .is_write_i  (is_write_i),
      .wrap_mask_o (dec_mask),
      .full_o      (dec_full)
   );

   bcg_beat_seq #(.COL_W(COL_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .start_col_i (start_col_i),
      .mask_i      (dec_mask),
      .full_i      (dec_full),
      .ilv_i       (ilv_mode_i),
      .advance_i   (advance_i),
      .terminate_i (terminate_i),
      .active_o    (valid_o),
      .beat_o      (beat_q),
      .base_o      (base_q),
      .mask_o      (mask_q),
      .ilv_o       (ilv_q),
      .last_o      (last_o)
   );

   bcg_col_map #(.COL_W(COL_W), .ILV_EN(ILV_EN)) u_map (
      .active_i (valid_o),
      .base_i   (base_q),
      .beat_i   (beat_q),
      .mask_i   (mask_q),
      .ilv_i    (ilv_q),
      .col_o    (col_o)
   );

endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
   parameter int COL_W = 9
)(
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [COL_W-1:0] start_col_i,
   input logic [2:0]       bl_code_i,
   input logic             single_wr_i,
   input logic             is_write_i,
   input logic             advance_i,
   input logic             terminate_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o
);

   // remembers whether the running burst was started as full page
   logic page_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       page_run <= 1'b0;
      else if (start_i) page_run <= (bl_code_i == 3'd7) && !(single_wr_i && is_write_i);
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> (col_o == '0) && !last_o);

   p_start_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> valid_o && (col_o == $past(start_col_i)));

   p_last_in_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && last_o && advance_i && !start_i && !terminate_i |=> !valid_o);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !advance_i && !start_i && !terminate_i |=> valid_o && $stable(col_o));

   p_page_nolast_r8: assert property (@(posedge clk) disable iff (!rst_n)
      page_run && valid_o |-> !last_o);

   p_term_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && terminate_i && !start_i |=> !valid_o);

   p_single_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && single_wr_i && is_write_i |=> last_o);

endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .start_col_i (start_col_i),
   .bl_code_i   (bl_code_i),
   .single_wr_i (single_wr_i),
   .is_write_i  (is_write_i),
   .advance_i   (advance_i),
   .terminate_i (terminate_i),
   .col_o       (col_o),
   .valid_o     (valid_o),
   .last_o      (last_o)
);

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [8:0] start_col_i = '0;
   logic [2:0] bl_code_i = '0;
   logic       ilv_mode_i = 1'b0;
   logic       single_wr_i = 1'b0;
   logic       is_write_i = 1'b0;
   logic       advance_i = 1'b0;
   logic       terminate_i = 1'b0;
   logic [8:0] col_o;
   logic       valid_o;
   logic       last_o;

   always #10 clk = ~clk;

   sdram_burst_colgen uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .bl_code_i(bl_code_i), .ilv_mode_i(ilv_mode_i), .single_wr_i(single_wr_i),
      .is_write_i(is_write_i), .advance_i(advance_i), .terminate_i(terminate_i),
      .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
   );

   typedef struct {
      logic       v;
      logic [8:0] c;
      logic       l;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   // reference model state
   bit m_act = 0;
   int m_beat = 0, m_base = 0, m_len = 1;
   bit m_ilv = 0;

   // drive one cycle and queue the expected visible state after the next edge
   task automatic cyc(input bit st, input int scol, input int code, input bit ilv,
                      input bit sw, input bit wr, input bit adv, input bit term,
                      input string tag);
      exp_t e;
      bit   was_last;
      int   lo;
      @(negedge clk);
      start_i = st; start_col_i = scol[8:0]; bl_code_i = code[2:0];
      ilv_mode_i = ilv; single_wr_i = sw; is_write_i = wr;
      advance_i = adv; terminate_i = term;
      was_last = m_act && (m_len != 0) && (m_beat == m_len - 1);
      if (st) begin
         m_act = 1; m_beat = 0; m_base = scol;
         if (sw && wr) m_len = 1;
         else case (code)
            1: m_len = 2; 2: m_len = 4; 3: m_len = 8; 7: m_len = 0;
            default: m_len = 1;
         endcase
         m_ilv = ilv && (m_len != 0);
      end else if (m_act) begin
         if (term) m_act = 0;
         else if (adv) begin
            if (was_last) m_act = 0;
            else m_beat++;
         end
      end
      e.tag = tag;
      if (!m_act) begin
         e.v = 0; e.c = '0; e.l = 0;
      end else begin
         e.v = 1;
         if (m_len == 0) e.c = 9'((m_base + m_beat) % 512);
         else if (m_ilv) e.c = 9'(m_base ^ m_beat);
         else begin
            lo  = m_base % m_len;
            e.c = 9'(m_base - lo + (lo + m_beat) % m_len);
         end
         e.l = (m_len != 0) && (m_beat == m_len - 1);
      end
      q.push_back(e);
   endtask

   // monitor: compare a quarter period after each rising edge
   always @(posedge clk) begin
      exp_t e;
      #5;
      if (q.size() > 0) begin
         e = q.pop_front();
         n_checks++;
         if (valid_o !== e.v || col_o !== e.c || last_o !== e.l) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b col=%0h last=%0b, expected valid=%0b col=%0h last=%0b",
                     e.tag, valid_o, col_o, last_o, e.v, e.c, e.l);
         end
      end
   end

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: got run still active, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #35;
      n_checks++;
      if (valid_o !== 1'b0 || col_o !== 9'h0 || last_o !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 reset: got valid=%0b col=%0h last=%0b, expected 0 0 0",
                  valid_o, col_o, last_o);
      end
      @(negedge clk); rst_n = 1'b1;

      // R1: advance and terminate alone leave the block idle
      cyc(0, 0, 3, 0, 0, 0, 1, 0, "R1");
      cyc(0, 0, 3, 0, 0, 0, 0, 1, "R1");

      // R3: sequential 8-beat from 0x1F5 wraps inside its group
      cyc(1, 'h1F5, 3, 0, 0, 0, 0, 0, "R2");
      for (int i = 0; i < 8; i++) cyc(0, 0, 3, 0, 0, 0, 1, 0, "R3");
      cyc(0, 0, 3, 0, 0, 0, 1, 0, "R6");

      // R4: interleaved 8-beat and 4-beat
      cyc(1, 'h0A3, 3, 1, 0, 0, 0, 0, "R4");
      for (int i = 0; i < 8; i++) cyc(0, 0, 3, 1, 0, 0, 1, 0, "R4");
      cyc(1, 'h12E, 2, 1, 0, 0, 0, 0, "R4");
      for (int i = 0; i < 4; i++) cyc(0, 0, 2, 1, 0, 0, 1, 0, "R4");

      // R5: 2-beat, 1-beat, and reserved code 5 as 1 beat
      cyc(1, 'h0FF, 1, 0, 0, 0, 0, 0, "R5");
      for (int i = 0; i < 2; i++) cyc(0, 0, 1, 0, 0, 0, 1, 0, "R5");
      cyc(1, 'h033, 0, 0, 0, 0, 0, 0, "R5");
      cyc(0, 0, 0, 0, 0, 0, 1, 0, "R5");
      cyc(1, 'h044, 5, 0, 0, 0, 0, 0, "R5");
      cyc(0, 0, 5, 0, 0, 0, 1, 0, "R5");

      // R6 and R7: 4-beat with stalls; R2: mode change mid burst ignored
      cyc(1, 'h10A, 2, 0, 0, 0, 0, 0, "R6");
      cyc(0, 0, 7, 1, 0, 0, 1, 0, "R2");
      cyc(0, 0, 7, 1, 0, 0, 0, 0, "R7");
      cyc(0, 0, 7, 1, 0, 0, 0, 0, "R7");
      cyc(0, 0, 2, 0, 0, 0, 1, 0, "R6");
      cyc(0, 0, 2, 0, 0, 0, 1, 0, "R6");
      cyc(0, 0, 2, 0, 0, 0, 0, 0, "R6");
      cyc(0, 0, 2, 0, 0, 0, 1, 0, "R6");

      // R8: full page from 0x1FD with interleave requested, wraps past 511
      cyc(1, 'h1FD, 7, 1, 0, 0, 0, 0, "R8");
      for (int i = 0; i < 6; i++) cyc(0, 0, 7, 1, 0, 0, 1, 0, "R8");
      cyc(0, 0, 7, 1, 0, 0, 1, 1, "R9");
      // R8: longer than one row
      cyc(1, 'h005, 7, 0, 0, 0, 0, 0, "R8");
      for (int i = 0; i < 520; i++) cyc(0, 0, 7, 0, 0, 0, 1, 0, "R8");
      cyc(0, 0, 7, 0, 0, 0, 0, 1, "R9");

      // R9: terminate mid 8-beat with advance
      cyc(1, 'h060, 3, 0, 0, 0, 0, 0, "R9");
      cyc(0, 0, 3, 0, 0, 0, 1, 0, "R9");
      cyc(0, 0, 3, 0, 0, 0, 1, 1, "R9");
      cyc(0, 0, 3, 0, 0, 0, 1, 0, "R9");

      // R10: restart mid burst, and start with terminate in same cycle
      cyc(1, 'h077, 3, 0, 0, 0, 0, 0, "R10");
      cyc(0, 0, 3, 0, 0, 0, 1, 0, "R10");
      cyc(1, 'h1C2, 3, 1, 0, 0, 1, 0, "R10");
      cyc(0, 0, 3, 1, 0, 0, 1, 0, "R10");
      cyc(1, 'h0D9, 2, 0, 0, 0, 1, 1, "R10");
      for (int i = 0; i < 4; i++) cyc(0, 0, 2, 0, 0, 0, 1, 0, "R10");

      // R11: single write cuts an 8-beat and a full page write to 1 beat
      cyc(1, 'h0B6, 3, 0, 1, 1, 0, 0, "R11");
      cyc(0, 0, 3, 0, 1, 1, 1, 0, "R11");
      cyc(1, 'h1FF, 7, 0, 1, 1, 0, 0, "R11");
      cyc(0, 0, 7, 0, 1, 1, 1, 0, "R11");
      cyc(1, 'h0B6, 3, 0, 1, 0, 0, 0, "R11");
      for (int i = 0; i < 8; i++) cyc(0, 0, 3, 0, 1, 0, 1, 0, "R11");

      cyc(0, 0, 0, 0, 0, 0, 0, 0, "R1");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule